// File: doc/BRIEF.md
# Triggered Rank-Ordered Conversion Sequencer

This block drives a single shared analog-to-digital converter through a short burst of conversions. A rising edge on the trigger input starts a burst. At that instant the block takes a snapshot of the per-rank channel numbers and of the number of ranks to use. It then asks the converter for one result per rank, from rank 0 upward. It uses a plain start/done handshake for this.

Each result lands in a register owned by its rank. Any consumer can read that register at any time, with no interrupt or transfer engine involved. A register keeps its value until a later burst overwrites it, whether or not anyone read the old value. A valid bit per rank shows which registers the current burst has filled. A one-clock end-of-burst pulse marks completion. A sticky flag records any trigger edge that arrived while a burst was still running and was therefore dropped.

Top module: `trig_rank_sequencer`

## Requirements
- R1: A burst starts only when the trigger is low in one sampled cycle and high in the next (a rising edge). A trigger held high, or a falling edge, never starts a burst.
- R2: The rank count and all per-rank channel numbers are captured at the accepted edge. Changes to those inputs during a burst do not affect that burst.
- R3: The block requests conversions in ascending rank order. Each request is a one-cycle `conv_start_o` pulse, with `conv_chan_o` holding that rank's captured channel. The next request is issued only after `conv_done_i` returns.
- R4: On `conv_done_i`, `conv_data_i` is written into the register of the rank being converted (rank r occupies `result_o[r*DATA_W +: DATA_W]`). That rank's valid bit (`valid_o[r]`) is set.
- R5: A result register changes only when its rank is written. Data from a new burst replaces the old contents whether or not they were read.
- R6: The effective rank count is `rank_count_i`, limited to the range 1 to MAX_RANKS (0 acts as 1, values above MAX_RANKS act as MAX_RANKS). Ranks at or above the effective count are not converted, and their registers keep their old data.
- R7: A rising trigger edge that arrives while a burst is running is ignored and starts no extra conversion. It sets `missed_o`, which stays set until reset.
- R8: `eos_o` is high for exactly one clock. That clock is the one right after the last rank's `conv_done_i` is sampled.
- R9: All valid bits are cleared in the cycle after a burst is accepted.
- R10: After reset, all result registers, valid bits, `conv_start_o`, `eos_o` and `missed_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | External trigger; a rising edge starts a burst |
| rank_count_i | input | CNT_W | Requested number of ranks (clamped to 1..MAX_RANKS) |
| rank_chan_i | input | MAX_RANKS*CH_W | Channel number per rank, rank r at bits r*CH_W +: CH_W |
| conv_data_i | input | DATA_W | Converter result |
| conv_done_i | input | 1 | Converter result valid, one cycle |
| conv_chan_o | output | CH_W | Channel to convert |
| conv_start_o | output | 1 | One-cycle conversion request |
| result_o | output | MAX_RANKS*DATA_W | Per-rank result registers |
| valid_o | output | MAX_RANKS | Per-rank valid bits |
| eos_o | output | 1 | End-of-burst pulse |
| missed_o | output | 1 | Sticky flag for a dropped trigger edge |

## Verification
The embedded assertions check the local, cycle-level rules on every clock:
- `conv_start_o` and `eos_o` are single-cycle pulses.
- `missed_o` is sticky.
- Nothing is requested from idle without a rising edge.
- Requests never go past the captured last rank.
- A rank's register holds its value unless that rank is written.
- Writes set the valid bit, and acceptance clears all valid bits.

Only the bench scenarios can show the end-to-end behaviour:
- The order of channels actually requested.
- That the captured configuration survives later changes to the inputs.
- That stored values match what the converter returned for each rank.
- The clamping of the rank count.
- That a held-high trigger or a trigger during a burst does not start extra conversions.

// File: rtl/trig_rank_sequencer_pkg.sv
package trig_rank_sequencer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_i;
        rise_o = trig_i & ~trig_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end
endmodule

// File: rtl/rank_sched_fsm.sv
module rank_sched_fsm
    import trig_rank_sequencer_pkg::*;
#(
    parameter int MAX_RANKS = 4,
    parameter int CH_W      = 5,
    parameter int CNT_W     = 3,
    parameter int IDX_W     = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rise_i,
    input  logic [CNT_W-1:0]                 rank_count_i,
    input  logic [MAX_RANKS-1:0][CH_W-1:0]   rank_chan_i,
    input  logic                             conv_done_i,
    output logic                             conv_start_o,
    output logic [CH_W-1:0]                  conv_chan_o,
    output logic [MAX_RANKS-1:0]             wr_o,
    output logic                             clr_o,
    output logic                             eos_o,
    output logic                             missed_o
);
    typedef struct packed {
        seq_state_t                     st;
        logic [IDX_W-1:0]               idx;
        logic [IDX_W-1:0]               last;
        logic [MAX_RANKS-1:0][CH_W-1:0] chan;
        logic                           missed;
        logic                           eos;
    } fsm_t;

    fsm_t             fsm_d, fsm_q;
    logic [CNT_W-1:0] cnt_c;

    always_comb begin
        fsm_d = fsm_q;
        fsm_d.eos = 1'b0;
        wr_o  = '0;
        clr_o = 1'b0;

        if (rank_count_i == '0)
            cnt_c = CNT_W'(1);
        else if (rank_count_i > CNT_W'(MAX_RANKS))
            cnt_c = CNT_W'(MAX_RANKS);
        else
            cnt_c = rank_count_i;

        case (fsm_q.st)
            ST_IDLE: begin
                if (rise_i) begin
                    fsm_d.st   = ST_ISSUE;
                    fsm_d.idx  = '0;
                    fsm_d.last = IDX_W'(cnt_c - CNT_W'(1));
                    fsm_d.chan = rank_chan_i;
                    clr_o      = 1'b1;
                end
            end
            ST_ISSUE: begin
                fsm_d.st = ST_WAIT;
                if (rise_i) fsm_d.missed = 1'b1;
            end
            ST_WAIT: begin
                if (rise_i) fsm_d.missed = 1'b1;
                if (conv_done_i) begin
                    wr_o = MAX_RANKS'(1) << fsm_q.idx;
                    if (fsm_q.idx == fsm_q.last) begin
                        fsm_d.st  = ST_IDLE;
                        fsm_d.eos = 1'b1;
                    end else begin
                        fsm_d.idx = fsm_q.idx + IDX_W'(1);
                        fsm_d.st  = ST_ISSUE;
                    end
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase

        conv_start_o = (fsm_q.st == ST_ISSUE);
        conv_chan_o  = fsm_q.chan[fsm_q.idx];
        eos_o        = fsm_q.eos;
        missed_o     = fsm_q.missed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
    assert_start_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (fsm_q.idx <= fsm_q.last));
    assert_idle_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE && !rise_i) |=> !conv_start_o);
    assert_eos_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |=> !eos_o);
    assert_missed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        missed_o |=> missed_o);
endmodule

// File: rtl/rank_result_bank.sv
module rank_result_bank #(
    parameter int MAX_RANKS = 4,
    parameter int DATA_W    = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [MAX_RANKS-1:0]               wr_i,
    input  logic                               clr_i,
    input  logic [DATA_W-1:0]                  data_i,
    output logic [MAX_RANKS-1:0][DATA_W-1:0]   data_o,
    output logic [MAX_RANKS-1:0]               valid_o
);
    logic [MAX_RANKS-1:0][DATA_W-1:0] data_d, data_q;
    logic [MAX_RANKS-1:0]             valid_d, valid_q;

    for (genvar r = 0; r < MAX_RANKS; r++) begin : g_rank
        always_comb begin
            data_d[r]  = data_q[r];
            valid_d[r] = valid_q[r];
            if (clr_i)  valid_d[r] = 1'b0;
            if (wr_i[r]) begin
                data_d[r]  = data_i;
                valid_d[r] = 1'b1;
            end
        end

        assert_hold_unwritten_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_i[r] |=> $stable(data_q[r]));
        assert_valid_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_i[r] |=> valid_q[r]);
        assert_valid_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> !valid_q[r]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/trig_rank_sequencer.sv
module trig_rank_sequencer #(
    parameter int MAX_RANKS = 4,
    parameter int CH_W      = 5,
    parameter int DATA_W    = 12,
    localparam int CNT_W    = $clog2(MAX_RANKS + 1),
    localparam int IDX_W    = (MAX_RANKS > 1) ? $clog2(MAX_RANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        trig_i,
    input  logic [CNT_W-1:0]            rank_count_i,
    input  logic [MAX_RANKS*CH_W-1:0]   rank_chan_i,
    input  logic [DATA_W-1:0]           conv_data_i,
    input  logic                        conv_done_i,
    output logic [CH_W-1:0]             conv_chan_o,
    output logic                        conv_start_o,
    output logic [MAX_RANKS*DATA_W-1:0] result_o,
    output logic [MAX_RANKS-1:0]        valid_o,
    output logic                        eos_o,
    output logic                        missed_o
);
    logic                             rise;
    logic [MAX_RANKS-1:0]             wr;
    logic                             clr;
    logic [MAX_RANKS-1:0][CH_W-1:0]   chan_2d;
    logic [MAX_RANKS-1:0][DATA_W-1:0] res_2d;

    assign chan_2d  = rank_chan_i;
    assign result_o = res_2d;

    trig_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    rank_sched_fsm #(
        .MAX_RANKS (MAX_RANKS),
        .CH_W      (CH_W),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (rise),
        .rank_count_i (rank_count_i),
        .rank_chan_i  (chan_2d),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .conv_chan_o  (conv_chan_o),
        .wr_o         (wr),
        .clr_o        (clr),
        .eos_o        (eos_o),
        .missed_o     (missed_o)
    );

    rank_result_bank #(
        .MAX_RANKS (MAX_RANKS),
        .DATA_W    (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .clr_i   (clr),
        .data_i  (conv_data_i),
        .data_o  (res_2d),
        .valid_o (valid_o)
    );

    assert_eos_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |-> $past(|wr));
endmodule

// File: tb/trig_rank_sequencer_bench.sv
module trig_rank_sequencer_bench;
    localparam int NR = 4;
    localparam int CW = 5;
    localparam int DW = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                trig_i = 1'b0;
    logic [2:0]          rank_count_i = 3'd1;
    logic [NR*CW-1:0]    rank_chan_i = '0;
    logic [DW-1:0]       conv_data_i = '0;
    logic                conv_done_i = 1'b0;
    logic [CW-1:0]       conv_chan_o;
    logic                conv_start_o;
    logic [NR*DW-1:0]    result_o;
    logic [NR-1:0]       valid_o;
    logic                eos_o;
    logic                missed_o;

    int checks = 0;
    int errors = 0;
    int batch = 0;
    int stub_lat = 1;
    int stub_cnt = 0;
    bit stub_busy = 0;
    logic [CW-1:0] stub_chan = '0;
    int log_ch [0:1023];
    int log_n = 0;
    int eos_n = 0;
    int exp_data [NR];
    bit exp_valid [NR];
    bit exp_missed = 0;

    trig_rank_sequencer u_trig_rank_sequencer (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .rank_count_i(rank_count_i),
        .rank_chan_i(rank_chan_i), .conv_data_i(conv_data_i), .conv_done_i(conv_done_i),
        .conv_chan_o(conv_chan_o), .conv_start_o(conv_start_o), .result_o(result_o),
        .valid_o(valid_o), .eos_o(eos_o), .missed_o(missed_o)
    );

    always #10 clk = ~clk;

    function automatic int conv_val(int ch, int b);
        return (ch * 53 + b * 29 + 7) & 12'hFFF;
    endfunction

    function automatic int eff_count(int c);
        if (c == 0) return 1;
        if (c > NR) return NR;
        return c;
    endfunction

    // behavioural converter stub
    always @(posedge clk) begin
        conv_done_i <= 1'b0;
        if (!rst_n) begin
            stub_busy <= 0;
        end else if (conv_start_o) begin
            stub_busy <= 1;
            stub_cnt  <= stub_lat;
            stub_chan <= conv_chan_o;
            log_ch[log_n] <= int'(conv_chan_o);
            log_n <= log_n + 1;
        end else if (stub_busy) begin
            if (stub_cnt <= 1) begin
                conv_done_i <= 1'b1;
                conv_data_i <= DW'(conv_val(int'(stub_chan), batch));
                stub_busy   <= 0;
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
    end

    always @(posedge clk) if (eos_o) eos_n <= eos_n + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int r = 0; r < NR; r++) begin
            chk(int'(result_o[r*DW +: DW]) == exp_data[r], req, int'(result_o[r*DW +: DW]), exp_data[r]);
            chk(valid_o[r] == exp_valid[r], req, int'(valid_o[r]), int'(exp_valid[r]));
        end
    endtask

    // one burst; chg: alter config after acceptance; glitch: extra edge while busy;
    // hold: keep trigger high after the burst
    task automatic run_seq(input int cnt, input logic [NR*CW-1:0] chans, input int lat,
                           input bit chg, input bit glitch, input bit hold);
        int eff, base, e0, got;
        eff = eff_count(cnt);
        base = log_n;
        e0 = eos_n;
        stub_lat = lat;
        @(negedge clk);
        batch++;
        rank_count_i = 3'(cnt);
        rank_chan_i  = chans;
        trig_i = 1'b1;
        @(negedge clk);
        chk(valid_o == '0, "R9 valid cleared", int'(valid_o), 0);
        chk(conv_start_o == 1'b1, "R3 first start", int'(conv_start_o), 1);
        if (chg) begin
            rank_chan_i  = ~chans;
            rank_count_i = 3'd4;
        end
        if (glitch) begin
            trig_i = 1'b0;
            @(negedge clk);
            trig_i = 1'b1;
            exp_missed = 1;
        end
        got = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (eos_o) begin got = 1; break; end
        end
        chk(got == 1, "R8 eos seen", got, 1);
        chk(log_n - base == eff, "R6 conversion count", log_n - base, eff);
        for (int k = 0; k < eff; k++) begin
            chk(log_ch[base + k] == int'(chans[k*CW +: CW]), "R3 R2 channel order",
                log_ch[base + k], int'(chans[k*CW +: CW]));
        end
        for (int r = 0; r < NR; r++) begin
            if (r < eff) begin
                exp_data[r]  = conv_val(int'(chans[r*CW +: CW]), batch);
                exp_valid[r] = 1;
            end else begin
                exp_valid[r] = 0;
            end
        end
        check_bank("R4 R5 R6 bank");
        chk(missed_o == exp_missed, "R7 missed flag", int'(missed_o), int'(exp_missed));
        @(negedge clk);
        chk(eos_o == 1'b0, "R8 eos one cycle", int'(eos_o), 0);
        chk(eos_n - e0 == 1, "R8 eos count", eos_n - e0, 1);
        if (hold) begin
            base = log_n;
            repeat (10) @(negedge clk);
            chk(log_n == base, "R1 level ignored", log_n - base, 0);
            trig_i = 1'b0;
            repeat (10) @(negedge clk);
            chk(log_n == base, "R1 falling ignored", log_n - base, 0);
            check_bank("R5 hold after burst");
        end
        trig_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NR*CW-1:0] ch;
        void'($urandom(32'd4711));
        for (int r = 0; r < NR; r++) begin exp_data[r] = 0; exp_valid[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(result_o == '0, "R10 results", int'(result_o[DW-1:0]), 0);
        chk(valid_o == '0, "R10 valid", int'(valid_o), 0);
        chk({conv_start_o, eos_o, missed_o} == 3'b000, "R10 flags",
            int'({conv_start_o, eos_o, missed_o}), 0);

        // directed: full burst, then level/falling trigger ignored
        run_seq(4, {5'd3, 5'd17, 5'd9, 5'd30}, 2, 0, 0, 1);
        // R6: 2 ranks, upper ranks keep data
        run_seq(2, {5'd1, 5'd2, 5'd5, 5'd6}, 1, 0, 0, 0);
        // R6: count 0 acts as 1, count 7 acts as 4
        run_seq(0, {5'd8, 5'd8, 5'd8, 5'd11}, 3, 0, 0, 0);
        run_seq(7, {5'd21, 5'd22, 5'd23, 5'd24}, 1, 0, 0, 0);
        // R2: config changed mid-burst
        run_seq(3, {5'd0, 5'd12, 5'd13, 5'd14}, 4, 1, 0, 0);
        // R7: edge during burst
        run_seq(2, {5'd4, 5'd5, 5'd6, 5'd7}, 4, 0, 1, 0);
        // random mix
        for (int t = 0; t < 30; t++) begin
            ch = NR*CW'($urandom);
            run_seq(int'($urandom_range(0, 7)), ch, int'($urandom_range(1, 5)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule